// File: doc/BRIEF.md
# Exhaustive Spare Allocation Search

This block finishes redundancy analysis for a memory with a fixed supply of row spares and column spares. Fault collection, which happens elsewhere, has already reduced the faults to a small set of pivots: faults that share neither a row nor a column with each other. It has also produced a cross map that records which non-pivot faults sit on the row of one pivot and the column of another. Lines that are already decided, either because a line holds too many faults or because a tail fault fixes the direction of repair, arrive as per-pivot forced-row and forced-column masks.

On a start pulse the block captures these inputs. It subtracts the forced decisions from the spare supply to get the spares still free. It then walks every candidate set of pivot columns, one per clock in ascending code order. For each candidate it works out which pivot rows would still be needed to cover the pivots and cross faults that are left. The first candidate that fits both the free column and free row budgets becomes the answer. That answer is written as per-pivot row and column solution bits together with a repairable flag. If no candidate fits, the block raises an unrepairable flag and clears the solution bits. Either result comes with a one-cycle done pulse.

Top module: `spare_search`

## Requirements
- R1: After reset, busy, done, repairable and unrepairable are low, and both solution vectors are zero.
- R2: The free budgets are RS minus the number of forced rows and CS minus the number of forced columns. If either count exceeds its supply, no candidate is accepted and the run ends unrepairable.
- R3: Candidate codes are examined in ascending order from 0, one per clock. A run that accepts code c raises done c+1 clocks after the clock edge that samples start. A run that accepts nothing raises done 2^(RS+CS) clocks after that edge.
- R4: Bit j of a candidate chooses a column spare for pivot j. Pivot row i is needed when i is valid, not forced to a row, and either its own column is not in candidate|forced-columns or some cross bit (i,j) has its column j outside that set. A candidate is accepted when its bits all name valid pivots, its columns beyond the forced ones number at most the free column budget, and the needed rows number at most the free row budget.
- R5: Cross-map bit i*(RS+CS)+j marks a fault on pivot i's row and pivot j's column. Diagonal bits are ignored, and so are bits that name a pivot at or above pivot_cnt. Pivots occupy indices 0 to pivot_cnt-1.
- R6: On acceptance, sol_row is the forced rows plus the needed rows, sol_col is the candidate plus the forced columns, and repairable is set. These outputs hold until the next accepted start.
- R7: When pivot_cnt equals RS+CS and no line is forced, every pivot ends with exactly one spare, either a row or a column.
- R8: With no row spare free, every remaining pivot must take a column. A cross fault whose row would still be needed makes the run unrepairable.
- R9: A run that accepts nothing sets unrepairable, clears repairable, and leaves both solution vectors zero.
- R10: done is high for exactly one clock per run, and busy is high from the clock after start until the clock that raises done.
- R11: A start pulse that arrives while busy is ignored, and the run in progress finishes with its own captured inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Captures inputs and begins a search when idle |
| pivot_cnt | input | $clog2(RS+CS+1) | Number of valid pivots |
| row_forced | input | RS+CS | Pivots whose row already holds a row spare |
| col_forced | input | RS+CS | Pivots whose column already holds a column spare |
| cross_map | input | (RS+CS)^2 | Cross faults, bit i*(RS+CS)+j = row of pivot i, column of pivot j |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse at end of a search |
| repairable | output | 1 | Last search found a solution |
| unrepairable | output | 1 | Last search found no solution |
| sol_row | output | RS+CS | Pivots whose row receives a row spare |
| sol_col | output | RS+CS | Pivots whose column receives a column spare |

## Verification
The checks assume that the forced masks only mark pivots below pivot_cnt and never mark the same pivot in both directions. Only under that assumption do the solution-size bounds follow from the free budgets. The stimulus keeps every forced bit inside the valid pivot range. Cross-map bits outside that range, and diagonal bits, appear only where they are meant to be ignored. Inputs need only be valid in the cycle that samples start, and the bench changes them freely during a search to show that they are captured.

// File: rtl/spare_search_pkg.sv
package spare_search_pkg;

    typedef enum logic {
        ST_IDLE,
        ST_SCAN
    } scan_state_e;

    // number of set bits in a vector of up to 32 bits
    function automatic int unsigned ones32(input logic [31:0] v);
        int unsigned n;
        n = 0;
        for (int k = 0; k < 32; k++) begin
            n += int'(v[k]);
        end
        return n;
    endfunction

endpackage

// File: rtl/spare_budget.sv
module spare_budget
    import spare_search_pkg::*;
#(
    parameter int RS = 2,
    parameter int CS = 2,
    localparam int NP = RS + CS,
    localparam int CW = $clog2(NP + 1)
) (
    input  logic [NP-1:0] frow,
    input  logic [NP-1:0] fcol,
    output logic [CW-1:0] ra,
    output logic [CW-1:0] ca,
    output logic          fits
);
    int unsigned nrow;
    int unsigned ncol;

    always_comb begin
        nrow = ones32(32'(frow));
        ncol = ones32(32'(fcol));
        fits = (nrow <= RS) && (ncol <= CS);
        ra   = fits ? CW'(RS - int'(nrow)) : '0;
        ca   = fits ? CW'(CS - int'(ncol)) : '0;
    end
endmodule

// File: rtl/cover_eval.sv
module cover_eval
    import spare_search_pkg::*;
#(
    parameter int NP = 4,
    localparam int CW = $clog2(NP + 1),
    localparam int MW = NP * NP
) (
    input  logic [NP-1:0] cand,
    input  logic [NP-1:0] valid,
    input  logic [NP-1:0] frow,
    input  logic [NP-1:0] fcol,
    input  logic [MW-1:0] xmap,
    input  logic [CW-1:0] ra,
    input  logic [CW-1:0] ca,
    input  logic          fits,
    output logic [NP-1:0] need_row,
    output logic [NP-1:0] col_set,
    output logic          feasible
);
    logic [NP-1:0] open_col;
    int unsigned   extra;
    int unsigned   rows;

    assign col_set  = cand | fcol;
    assign open_col = valid & ~col_set;

    // one row-demand term per pivot
    for (genvar gi = 0; gi < NP; gi++) begin : g_row
        logic [NP-1:0] line;
        always_comb begin
            line     = xmap[gi*NP +: NP] & open_col;
            line[gi] = 1'b0;
        end
        assign need_row[gi] = valid[gi] & ~frow[gi] & (open_col[gi] | (|line));
    end

    always_comb begin
        extra    = ones32(32'(cand & ~fcol));
        rows     = ones32(32'(need_row));
        feasible = fits
                && ((cand & ~valid) == '0)
                && (extra <= 32'(ca))
                && (rows <= 32'(ra));
    end
endmodule

// File: rtl/spare_search.sv
module spare_search
    import spare_search_pkg::*;
#(
    parameter int RS = 2,
    parameter int CS = 2,
    localparam int NP = RS + CS,
    localparam int MW = NP * NP,
    localparam int CW = $clog2(NP + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] pivot_cnt,
    input  logic [NP-1:0] row_forced,
    input  logic [NP-1:0] col_forced,
    input  logic [MW-1:0] cross_map,
    output logic          busy,
    output logic          done,
    output logic          repairable,
    output logic          unrepairable,
    output logic [NP-1:0] sol_row,
    output logic [NP-1:0] sol_col
);
    scan_state_e   state;
    logic [CW-1:0] cap_cnt;
    logic [NP-1:0] cap_frow;
    logic [NP-1:0] cap_fcol;
    logic [MW-1:0] cap_map;
    logic [NP-1:0] cand;
    logic [NP-1:0] valid;
    logic [CW-1:0] ra;
    logic [CW-1:0] ca;
    logic          fits;
    logic [NP-1:0] need_row;
    logic [NP-1:0] col_set;
    logic          feasible;

    for (genvar gv = 0; gv < NP; gv++) begin : g_valid
        assign valid[gv] = (cap_cnt > CW'(gv));
    end

    spare_budget #(.RS(RS), .CS(CS)) u_budget (
        .frow (cap_frow),
        .fcol (cap_fcol),
        .ra   (ra),
        .ca   (ca),
        .fits (fits)
    );

    cover_eval #(.NP(NP)) u_eval (
        .cand     (cand),
        .valid    (valid),
        .frow     (cap_frow),
        .fcol     (cap_fcol),
        .xmap     (cap_map),
        .ra       (ra),
        .ca       (ca),
        .fits     (fits),
        .need_row (need_row),
        .col_set  (col_set),
        .feasible (feasible)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            cap_cnt      <= '0;
            cap_frow     <= '0;
            cap_fcol     <= '0;
            cap_map      <= '0;
            cand         <= '0;
            done         <= 1'b0;
            repairable   <= 1'b0;
            unrepairable <= 1'b0;
            sol_row      <= '0;
            sol_col      <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        cap_cnt      <= pivot_cnt;
                        cap_frow     <= row_forced;
                        cap_fcol     <= col_forced;
                        cap_map      <= cross_map;
                        cand         <= '0;
                        repairable   <= 1'b0;
                        unrepairable <= 1'b0;
                        state        <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (feasible) begin
                        sol_row    <= cap_frow | need_row;
                        sol_col    <= col_set;
                        repairable <= 1'b1;
                        done       <= 1'b1;
                        state      <= ST_IDLE;
                    end else if (&cand) begin
                        sol_row      <= '0;
                        sol_col      <= '0;
                        unrepairable <= 1'b1;
                        done         <= 1'b1;
                        state        <= ST_IDLE;
                    end else begin
                        cand <= cand + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state == ST_SCAN);
endmodule

// File: rtl/spare_search_chk.sv
module spare_search_chk #(
    parameter int RS = 2,
    parameter int CS = 2,
    localparam int NP = RS + CS
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          repairable,
    input logic          unrepairable,
    input logic [NP-1:0] sol_row,
    input logic [NP-1:0] sol_col
);
    // R10
    done_verdict_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (repairable ^ unrepairable));

    // R9
    verdict_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(repairable && unrepairable));

    // R9
    fail_clears_chk: assert property (@(posedge clk) disable iff (rst)
        unrepairable |-> (sol_row == '0 && sol_col == '0));

    // R2
    spare_budget_chk: assert property (@(posedge clk) disable iff (rst)
        repairable |-> ($countones(sol_row) <= RS && $countones(sol_col) <= CS));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R11
    restart_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !done) |=> (busy || done));
endmodule

bind spare_search spare_search_chk #(.RS(RS), .CS(CS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .busy         (busy),
    .done         (done),
    .repairable   (repairable),
    .unrepairable (unrepairable),
    .sol_row      (sol_row),
    .sol_col      (sol_col)
);

// File: tb/sim_spare_search.sv
`timescale 1ns/1ps
module sim_spare_search;
    localparam int RS = 2;
    localparam int CS = 2;
    localparam int NP = RS + CS;
    localparam int MW = NP * NP;
    localparam int CW = $clog2(NP + 1);
    localparam int NV = 10;

    typedef struct packed {
        logic [2:0]  cnt;
        logic [3:0]  frow;
        logic [3:0]  fcol;
        logic [15:0] xmap;
        logic        ok;
        logic [3:0]  erow;
        logic [3:0]  ecol;
        logic [4:0]  lat;
    } vec_t;

    // cnt, frow, fcol, map, ok, row, col, latency
    localparam logic [40:0] VEC [NV] = '{
        {3'd0, 4'h0, 4'h0, 16'h0000, 1'b1, 4'h0, 4'h0, 5'd1},  // R4 empty
        {3'd1, 4'h0, 4'h0, 16'h0000, 1'b1, 4'h1, 4'h0, 5'd1},  // R4 single pivot
        {3'd4, 4'h0, 4'h0, 16'h0000, 1'b1, 4'hC, 4'h3, 5'd4},  // R7 one spare each
        {3'd4, 4'h3, 4'h0, 16'h0100, 1'b0, 4'h0, 4'h0, 5'd16}, // R8 no rows left, cross blocks
        {3'd4, 4'h3, 4'h0, 16'h0000, 1'b1, 4'h3, 4'hC, 5'd13}, // R8 no rows left, columns fit
        {3'd4, 4'h2, 4'h0, 16'h4092, 1'b1, 4'h3, 4'hC, 5'd13}, // R4 cross faults
        {3'd3, 4'h0, 4'h1, 16'h0210, 1'b1, 4'h6, 4'h1, 5'd1},  // R2 forced column
        {3'd3, 4'h7, 4'h0, 16'h0000, 1'b0, 4'h0, 4'h0, 5'd16}, // R2 too many forced rows
        {3'd3, 4'h0, 4'h0, 16'h0356, 1'b0, 4'h0, 4'h0, 5'd16}, // R9 dense map
        {3'd1, 4'h0, 4'h0, 16'h1009, 1'b1, 4'h1, 4'h0, 5'd1}   // R5 ignored bits
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [CW-1:0] pivot_cnt = '0;
    logic [NP-1:0] row_forced = '0;
    logic [NP-1:0] col_forced = '0;
    logic [MW-1:0] cross_map = '0;
    logic          busy, done, repairable, unrepairable;
    logic [NP-1:0] sol_row, sol_col;

    int nchk = 0;
    int nfail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    spare_search #(.RS(RS), .CS(CS)) u0 (
        .clk(clk), .rst(rst), .start(start), .pivot_cnt(pivot_cnt),
        .row_forced(row_forced), .col_forced(col_forced), .cross_map(cross_map),
        .busy(busy), .done(done), .repairable(repairable),
        .unrepairable(unrepairable), .sol_row(sol_row), .sol_col(sol_col)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        pivot_cnt  = v.cnt;
        row_forced = v.frow;
        col_forced = v.fcol;
        cross_map  = v.xmap;
    endtask

    // launches at a negedge, returns at the negedge where done is seen
    task automatic launch_and_wait(input vec_t v, output int lat);
        apply(v);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 40) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
    endtask

    task automatic check_result(input vec_t v, input int lat, input int idx);
        chk($sformatf("R3 latency v%0d", idx), 32'(lat), 32'(v.lat));
        chk($sformatf("R6 repairable v%0d", idx), 32'(repairable), 32'(v.ok));
        chk($sformatf("R9 unrepairable v%0d", idx), 32'(unrepairable), 32'(!v.ok));
        chk($sformatf("R6 sol_row v%0d", idx), 32'(sol_row), 32'(v.erow));
        chk($sformatf("R6 sol_col v%0d", idx), 32'(sol_col), 32'(v.ecol));
        @(posedge clk);
        @(negedge clk);
        chk($sformatf("R10 done pulse v%0d", idx), 32'(done), 32'd0);
    endtask

    initial begin
        int lat;
        vec_t v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 busy", 32'(busy), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 repairable", 32'(repairable), 0);
        chk("R1 unrepairable", 32'(unrepairable), 0);
        chk("R1 sol_row", 32'(sol_row), 0);
        chk("R1 sol_col", 32'(sol_col), 0);

        for (int n = 0; n < NV; n++) begin
            v = vec_t'(VEC[n]);
            launch_and_wait(v, lat);
            check_result(v, lat, n);
        end

        // R6 result holds while idle
        repeat (3) @(negedge clk);
        chk("R6 hold repairable", 32'(repairable), 32'd1);
        chk("R10 idle busy", 32'(busy), 32'd0);

        // R11 restart during a search is ignored
        v = vec_t'(VEC[5]);
        apply(v);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        apply(vec_t'(VEC[7]));
        repeat (3) @(negedge clk);
        chk("R10 busy mid-run", 32'(busy), 32'd1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 4;
        while (!done && lat < 40) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        chk("R11 latency", 32'(lat), 32'd13);
        chk("R11 sol_row", 32'(sol_row), 32'h3);
        chk("R11 sol_col", 32'(sol_col), 32'hC);
        chk("R11 repairable", 32'(repairable), 32'd1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL R10 watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule